// File: doc/BRIEF.md
# Serial Loader Front End with Automatic Rate Detection

This block is the receive side of a serial loader. It stays idle until a pin combination asks for loading: the reset input held high while the program-store-enable line is pulled low, with both upper port select bits high or floating. If either select bit is low, the parallel load path owns the device and this block does nothing.

Once in load mode the block finds the host's baud rate from the first carriage return (0x0D) the host sends. The start bit of that character is followed by a 1 data bit, so the first low pulse on the line lasts exactly one bit period. The block counts that pulse in clock cycles and picks one of four fixed rates. It then receives bytes at that rate, folds lowercase letters to uppercase, and turns loader command letters into one-hot strobes with a 4-bit code. Unknown letters raise a separate strobe.

Top module: `sboot_front`

## Requirements
- R1: While `rst_pin` is low, `load_active`, `rate_locked`, `rx_valid`, `cmd_strobe` and `cmd_unknown` are all 0.
- R2: With `rst_pin` high, `psen_n` low and `sel_b7`, `sel_b6` both high, `load_active` rises within a few cycles and stays high until `rst_pin` falls.
- R3: If `sel_b7` or `sel_b6` is low at entry, `load_active` stays 0, and a carriage return on `rxd` neither locks a rate nor produces a byte.
- R4: The first low pulse after entry selects the rate code on `rate_sel` (0 = 9600, 1 = 2400, 2 = 1200, 3 = 300 bit/s). `baud_div` becomes that rate's nominal bit time in clock cycles (CLK_HZ / rate). `rate_locked` rises before the next character can start and then holds `rate_sel` steady.
- R5: A pulse is accepted when its width is within ±12% of a nominal bit time, measured in whole cycles. A 10% long pulse locks, and pulses 15% long or 17% short do not.
- R6: A rejected pulse rearms detection: a later pulse of valid width still locks, and no byte is delivered in the meantime.
- R7: Data bits are sampled at mid-bit, least significant bit first.
- R8: Each byte with a high stop bit appears on `rx_data` with a one-cycle `rx_valid` pulse, and only while `rate_locked` is high.
- R9: A byte whose stop bit is low is dropped: no `rx_valid` and no command strobe.
- R10: One cycle after `rx_valid`, a command letter raises exactly one bit of `cmd_strobe` for one cycle. `cmd_code` gives the same index. The index order is C=0, D=1, F=2, G=3, K=4, L=5, P=6, R=7, T=8, U=9, V=10, W=11, Z=12.
- R11: Lowercase letters (0x61 to 0x7A) decode the same as their uppercase forms.
- R12: Any other letter raises `cmd_unknown` for one cycle. A byte that is not a letter raises no strobe at all.
- R13: Taking `rst_pin` low leaves load mode and clears `rate_locked` and `baud_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin | input | 1 | Reset pin, active high; low clears the block |
| psen_n | input | 1 | Program-store-enable line, pulled low to request loading |
| sel_b7 | input | 1 | Upper port select bit 7, high selects serial load |
| sel_b6 | input | 1 | Upper port select bit 6, high selects serial load |
| rxd | input | 1 | Serial receive line, idle high |
| load_active | output | 1 | Serial load mode entered |
| rate_locked | output | 1 | Baud rate detected and receiver armed |
| rate_sel | output | 2 | Detected rate code |
| baud_div | output | DIV_W | Clock cycles per bit of the detected rate |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse per good byte |
| cmd_strobe | output | 13 | One-hot command strobes |
| cmd_unknown | output | 1 | Strobe for an unrecognised letter |
| cmd_code | output | 4 | Index of the last command strobed |

## Verification
The assertions assume `rst_pin` changes cleanly with respect to `clk`. They also assume it has been low for at least one clock edge before any check applies, because the reset pin doubles as the block's synchronous clear. The bench starts with the pin low and drives every input on falling clock edges. Serial traffic uses whole-cycle bit times, so pulse widths land exactly where the tolerance cases intend. The command-follows-byte and one-hot checks also assume no new byte can finish within one cycle of the previous one. This always holds because a frame lasts far longer than one cycle.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

  localparam int NUM_RATES = 4;
  localparam int SEL_W     = $clog2(NUM_RATES);
  localparam int NUM_CMDS  = 13;
  localparam int CODE_W    = 4;

  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    AB_WAIT_IDLE,
    AB_WAIT_FALL,
    AB_MEASURE,
    AB_SKIP,
    AB_LOCKED
  } ab_state_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_t;

  // Supported rates, fastest first; the index is the rate code.
  function automatic int unsigned rate_baud(input int idx);
    case (idx)
      0:       return 9600;
      1:       return 2400;
      2:       return 1200;
      default: return 300;
    endcase
  endfunction

  function automatic int unsigned rate_cycles(input int unsigned clk_hz, input int idx);
    return clk_hz / rate_baud(idx);
  endfunction

  // True when meas lies within +/-12% of nom (12% = 3/25).
  function automatic logic within_tol(input logic [31:0] meas, input logic [31:0] nom);
    logic [39:0] m25;
    logic [39:0] lo;
    logic [39:0] hi;
    m25 = {8'd0, meas} * 40'd25;
    lo  = {8'd0, nom} * 40'd22;
    hi  = {8'd0, nom} * 40'd28;
    return (m25 >= lo) && (m25 <= hi);
  endfunction

  function automatic byte_t fold_upper(input byte_t b);
    if (b >= 8'h61 && b <= 8'h7A) return b - 8'h20;
    return b;
  endfunction

  function automatic logic is_upper(input byte_t b);
    return (b >= 8'h41) && (b <= 8'h5A);
  endfunction

  // Returns {hit, index}.
  function automatic logic [CODE_W:0] cmd_lookup(input byte_t up);
    case (up)
      8'h43:   return {1'b1, 4'd0};   // C
      8'h44:   return {1'b1, 4'd1};   // D
      8'h46:   return {1'b1, 4'd2};   // F
      8'h47:   return {1'b1, 4'd3};   // G
      8'h4B:   return {1'b1, 4'd4};   // K
      8'h4C:   return {1'b1, 4'd5};   // L
      8'h50:   return {1'b1, 4'd6};   // P
      8'h52:   return {1'b1, 4'd7};   // R
      8'h54:   return {1'b1, 4'd8};   // T
      8'h55:   return {1'b1, 4'd9};   // U
      8'h56:   return {1'b1, 4'd10};  // V
      8'h57:   return {1'b1, 4'd11};  // W
      8'h5A:   return {1'b1, 4'd12};  // Z
      default: return {1'b0, 4'd0};
    endcase
  endfunction

endpackage

// File: rtl/sboot_sync.sv
module sboot_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (srst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sboot_autobaud.sv
module sboot_autobaud
  import sboot_pkg::*;
#(
  parameter  int unsigned CLK_HZ   = 11059200,
  localparam int unsigned NOM_SLOW = rate_cycles(CLK_HZ, NUM_RATES - 1),
  localparam int          DIV_W    = $clog2(NOM_SLOW + 1),
  localparam int          CNT_W    = DIV_W + 2,
  localparam int          SKIP_W   = DIV_W + 4
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             enable,
  input  logic             rxd,
  output logic             locked,
  output logic [SEL_W-1:0] rate_sel,
  output logic [DIV_W-1:0] baud_div,
  output logic             meas_done,
  output logic             meas_hit
);
  ab_state_t               state;
  logic [CNT_W-1:0]        cnt;
  logic [SKIP_W-1:0]       skip;
  logic [SKIP_W-1:0]       skip_target;
  logic [NUM_RATES-1:0]    hit;
  logic [DIV_W-1:0]        nom_tab [NUM_RATES];
  logic [SEL_W-1:0]        hit_sel;

  genvar gr;
  generate
    for (gr = 0; gr < NUM_RATES; gr++) begin : g_rate
      localparam int unsigned NOM = rate_cycles(CLK_HZ, gr);
      assign nom_tab[gr] = DIV_W'(NOM);
      assign hit[gr]     = within_tol(32'(cnt), 32'(NOM));
    end
  endgenerate

  always_comb begin
    hit_sel = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (hit[i]) hit_sel = SEL_W'(i);
    end
  end

  // Remaining eight data bits plus half the stop bit, counted from the
  // rising edge that ends the start bit.
  assign skip_target = (SKIP_W'(baud_div) << 3) + SKIP_W'(baud_div >> 1);

  assign meas_done = (state == AB_MEASURE) && rxd;
  assign meas_hit  = meas_done && (|hit);
  assign locked    = (state == AB_LOCKED);

  always_ff @(posedge clk) begin
    if (srst || !enable) begin
      state    <= AB_WAIT_IDLE;
      cnt      <= '0;
      skip     <= '0;
      rate_sel <= '0;
      baud_div <= '0;
    end else begin
      case (state)
        AB_WAIT_IDLE: if (rxd) state <= AB_WAIT_FALL;
        AB_WAIT_FALL: begin
          if (!rxd) begin
            cnt   <= CNT_W'(1);
            state <= AB_MEASURE;
          end
        end
        AB_MEASURE: begin
          if (!rxd) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
          end else if (|hit) begin
            rate_sel <= hit_sel;
            baud_div <= nom_tab[hit_sel];
            skip     <= '0;
            state    <= AB_SKIP;
          end else begin
            state <= AB_WAIT_FALL;
          end
        end
        AB_SKIP: begin
          if (skip == skip_target - 1'b1) state <= AB_LOCKED;
          else                            skip  <= skip + 1'b1;
        end
        default: state <= AB_LOCKED;
      endcase
    end
  end
endmodule

// File: rtl/sboot_rx.sv
module sboot_rx
  import sboot_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output byte_t            data,
  output logic             data_valid,
  output logic             frame_err
);
  rx_state_t        state;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bit_idx;
  byte_t            shreg;
  logic [DIV_W-1:0] half;
  logic             at_mid;

  assign half   = div >> 1;
  assign at_mid = (cnt == div - 1'b1);

  always_ff @(posedge clk) begin
    if (srst || !enable) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      data       <= '0;
      data_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      frame_err  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rxd) begin
            cnt   <= '0;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (cnt == half - 1'b1) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_mid) begin
            cnt     <= '0;
            shreg   <= {rxd, shreg[7:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) state <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_mid) begin
            cnt <= '0;
            if (rxd) begin
              data       <= shreg;
              data_valid <= 1'b1;
              state      <= RX_IDLE;
            end else begin
              frame_err <= 1'b1;
              state     <= RX_WAIT_HIGH;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: if (rxd) state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sboot_cmd.sv
module sboot_cmd
  import sboot_pkg::*;
(
  input  logic                clk,
  input  logic                srst,
  input  byte_t               byte_in,
  input  logic                byte_valid,
  output logic [NUM_CMDS-1:0] strobe,
  output logic                unknown,
  output logic [CODE_W-1:0]   code
);
  byte_t                 up;
  logic [CODE_W:0]       look;
  logic [NUM_CMDS-1:0]   onehot;

  assign up   = fold_upper(byte_in);
  assign look = cmd_lookup(up);

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CMDS; gc++) begin : g_hot
      assign onehot[gc] = look[CODE_W] && (look[CODE_W-1:0] == CODE_W'(gc));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (srst) begin
      strobe  <= '0;
      unknown <= 1'b0;
      code    <= '0;
    end else begin
      strobe  <= '0;
      unknown <= 1'b0;
      if (byte_valid) begin
        if (look[CODE_W]) begin
          strobe <= onehot;
          code   <= look[CODE_W-1:0];
        end else if (is_upper(up)) begin
          unknown <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sboot_front.sv
module sboot_front
  import sboot_pkg::*;
#(
  parameter  int unsigned CLK_HZ = 11059200,
  localparam int          DIV_W  = $clog2(rate_cycles(CLK_HZ, NUM_RATES - 1) + 1)
) (
  input  logic                clk,
  input  logic                rst_pin,
  input  logic                psen_n,
  input  logic                sel_b7,
  input  logic                sel_b6,
  input  logic                rxd,
  output logic                load_active,
  output logic                rate_locked,
  output logic [SEL_W-1:0]    rate_sel,
  output logic [DIV_W-1:0]    baud_div,
  output logic [7:0]          rx_data,
  output logic                rx_valid,
  output logic [NUM_CMDS-1:0] cmd_strobe,
  output logic                cmd_unknown,
  output logic [CODE_W-1:0]   cmd_code
);
  logic       srst;
  logic [3:0] pins_s;
  logic       psen_s, b7_s, b6_s, rxd_s;
  logic       entry_ok;
  logic       frame_err;
  logic       meas_done;
  logic       meas_hit;

  assign srst = !rst_pin;

  sboot_sync #(.W(4), .STAGES(2), .INIT(4'b1111)) u_sync (
    .clk  (clk),
    .srst (srst),
    .d    ({psen_n, sel_b7, sel_b6, rxd}),
    .q    (pins_s)
  );
  assign {psen_s, b7_s, b6_s, rxd_s} = pins_s;

  assign entry_ok = !psen_s && b7_s && b6_s;

  always_ff @(posedge clk) begin
    if (srst)                          load_active <= 1'b0;
    else if (!load_active && entry_ok) load_active <= 1'b1;
  end

  sboot_autobaud #(.CLK_HZ(CLK_HZ)) u_baud (
    .clk       (clk),
    .srst      (srst),
    .enable    (load_active),
    .rxd       (rxd_s),
    .locked    (rate_locked),
    .rate_sel  (rate_sel),
    .baud_div  (baud_div),
    .meas_done (meas_done),
    .meas_hit  (meas_hit)
  );

  sboot_rx #(.DIV_W(DIV_W)) u_rx (
    .clk        (clk),
    .srst       (srst),
    .enable     (rate_locked),
    .div        (baud_div),
    .rxd        (rxd_s),
    .data       (rx_data),
    .data_valid (rx_valid),
    .frame_err  (frame_err)
  );

  sboot_cmd u_cmd (
    .clk        (clk),
    .srst       (srst),
    .byte_in    (rx_data),
    .byte_valid (rx_valid),
    .strobe     (cmd_strobe),
    .unknown    (cmd_unknown),
    .code       (cmd_code)
  );
endmodule

// File: rtl/sboot_front_chk.sv
module sboot_front_chk
  import sboot_pkg::*;
(
  input logic                clk,
  input logic                rst_pin,
  input logic                load_active,
  input logic                rate_locked,
  input logic [SEL_W-1:0]    rate_sel,
  input logic                rx_valid,
  input logic [NUM_CMDS-1:0] cmd_strobe,
  input logic                cmd_unknown,
  input logic                entry_ok,
  input logic                frame_err,
  input logic                meas_done,
  input logic                meas_hit
);
  logic any_cmd;
  assign any_cmd = (|cmd_strobe) || cmd_unknown;

  a_r2_entry_cond: assert property (@(posedge clk) disable iff (!rst_pin)
    $rose(load_active) |-> $past(entry_ok));

  a_r13_lock_in_mode: assert property (@(posedge clk) disable iff (!rst_pin)
    rate_locked |-> load_active);

  a_r4_rate_hold: assert property (@(posedge clk) disable iff (!rst_pin)
    rate_locked |=> $stable(rate_sel));

  a_r6_reject_no_lock: assert property (@(posedge clk) disable iff (!rst_pin)
    (meas_done && !meas_hit) |=> !rate_locked);

  a_r8_byte_needs_lock: assert property (@(posedge clk) disable iff (!rst_pin)
    rx_valid |-> rate_locked);

  a_r9_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_pin)
    frame_err |=> !any_cmd);

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_pin)
    $onehot0({cmd_unknown, cmd_strobe}));

  a_r10_after_byte: assert property (@(posedge clk) disable iff (!rst_pin)
    any_cmd |-> $past(rx_valid));
endmodule

bind sboot_front sboot_front_chk u_chk (
  .clk         (clk),
  .rst_pin     (rst_pin),
  .load_active (load_active),
  .rate_locked (rate_locked),
  .rate_sel    (rate_sel),
  .rx_valid    (rx_valid),
  .cmd_strobe  (cmd_strobe),
  .cmd_unknown (cmd_unknown),
  .entry_ok    (entry_ok),
  .frame_err   (frame_err),
  .meas_done   (meas_done),
  .meas_hit    (meas_hit)
);

// File: tb/sboot_front_tb.sv
module sboot_front_tb;
  // 384 kHz nominal clock rate gives bit times of 40/160/320/1280 cycles.
  localparam int unsigned TB_CLK_HZ = 384000;
  localparam int          TB_DIV_W  = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_pin = 1'b0, psen_n = 1'b1, sel_b7 = 1'b1, sel_b6 = 1'b1, rxd = 1'b1;
  logic                load_active, rate_locked, rx_valid, cmd_unknown;
  logic [1:0]          rate_sel;
  logic [TB_DIV_W-1:0] baud_div;
  logic [7:0]          rx_data;
  logic [12:0]         cmd_strobe;
  logic [3:0]          cmd_code;

  sboot_front #(.CLK_HZ(TB_CLK_HZ)) u_dut (
    .clk(clk), .rst_pin(rst_pin), .psen_n(psen_n), .sel_b7(sel_b7), .sel_b6(sel_b6),
    .rxd(rxd), .load_active(load_active), .rate_locked(rate_locked), .rate_sel(rate_sel),
    .baud_div(baud_div), .rx_data(rx_data), .rx_valid(rx_valid), .cmd_strobe(cmd_strobe),
    .cmd_unknown(cmd_unknown), .cmd_code(cmd_code)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_unk = 0, n_rx = 0;
  int last_code = -1, last_bit = -1, last_rx = -1;
  bit finished = 0;

  always @(negedge clk) begin
    if (rx_valid) begin n_rx++; last_rx = rx_data; end
    if (cmd_unknown) n_unk++;
    if (cmd_strobe != 13'd0) begin
      n_cmd++;
      last_code = cmd_code;
      for (int i = 0; i < 13; i++) if (cmd_strobe[i]) last_bit = i;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input int n, input bit good_stop);
    @(negedge clk); rxd = 1'b0; repeat (n) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (n) @(negedge clk); end
    rxd = good_stop; repeat (n) @(negedge clk);
    rxd = 1'b1; repeat (2 * n) @(negedge clk);
  endtask

  task automatic low_pulse(input int n);
    @(negedge clk); rxd = 1'b0; repeat (n) @(negedge clk);
    rxd = 1'b1; repeat (100) @(negedge clk);
  endtask

  task automatic enter_mode();
    @(negedge clk); rst_pin = 1'b1; psen_n = 1'b0;
    repeat (6) @(negedge clk);
    psen_n = 1'b1;
    chk("R2 load_active", load_active, 1);
  endtask

  task automatic leave_mode();
    @(negedge clk); rst_pin = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic send_cmd(input string req, input logic [7:0] b, input int n, input int code);
    int c0, r0;
    c0 = n_cmd; r0 = n_rx;
    send_frame(b, n, 1'b1);
    chk({req, " strobe count"}, n_cmd - c0, 1);
    chk({req, " code"}, last_code, code);
    chk({req, " one-hot bit"}, last_bit, code);
    chk("R8 rx count", n_rx - r0, 1);
    chk("R7 rx byte", last_rx, int'(b));
  endtask

  task automatic t_reset();
    repeat (10) @(negedge clk);
    chk("R1 load_active", load_active, 0);
    chk("R1 rate_locked", rate_locked, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 strobes", int'({cmd_unknown, cmd_strobe}), 0);
  endtask

  task automatic t_parallel_owns();
    int r0;
    r0 = n_rx;
    sel_b7 = 1'b0;
    @(negedge clk); rst_pin = 1'b1; psen_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 load_active", load_active, 0);
    psen_n = 1'b1;
    send_frame(8'h0D, 40, 1'b1);
    chk("R3 rate_locked", rate_locked, 0);
    chk("R3 rx count", n_rx - r0, 0);
    leave_mode();
    sel_b7 = 1'b1;
  endtask

  task automatic t_tolerance();
    int r0;
    enter_mode();
    r0 = n_rx;
    low_pulse(46);
    chk("R5 46-cycle pulse rejected", rate_locked, 0);
    low_pulse(33);
    chk("R5 33-cycle pulse rejected", rate_locked, 0);
    chk("R6 no byte before lock", n_rx - r0, 0);
    send_frame(8'h0D, 44, 1'b1);
    chk("R6 rearmed lock", rate_locked, 1);
    chk("R5 rate_sel", rate_sel, 0);
    chk("R5 baud_div", baud_div, 40);
    chk("R8 no spurious byte", n_rx - r0, 0);
  endtask

  task automatic t_commands();
    int c0, u0, r0;
    send_cmd("R11 c", 8'h63, 40, 0);
    send_cmd("R10 Z", 8'h5A, 40, 12);
    send_cmd("R11 w", 8'h77, 40, 11);
    c0 = n_cmd; u0 = n_unk;
    send_frame(8'h78, 40, 1'b1);
    chk("R12 unknown letter", n_unk - u0, 1);
    chk("R12 no command", n_cmd - c0, 0);
    c0 = n_cmd; u0 = n_unk; r0 = n_rx;
    send_frame(8'h35, 40, 1'b1);
    chk("R12 digit no unknown", n_unk - u0, 0);
    chk("R12 digit no command", n_cmd - c0, 0);
    chk("R8 digit byte", last_rx, 8'h35);
    chk("R8 digit count", n_rx - r0, 1);
    c0 = n_cmd; r0 = n_rx;
    send_frame(8'h4C, 40, 1'b0);
    chk("R9 no byte", n_rx - r0, 0);
    chk("R9 no command", n_cmd - c0, 0);
    send_cmd("R10 L", 8'h4C, 40, 5);
  endtask

  task automatic t_leave();
    leave_mode();
    chk("R13 load_active", load_active, 0);
    chk("R13 rate_locked", rate_locked, 0);
    chk("R13 baud_div", baud_div, 0);
  endtask

  task automatic t_rate(input int n, input int sel, input logic [7:0] letter, input int code);
    leave_mode();
    enter_mode();
    send_frame(8'h0D, n, 1'b1);
    chk("R4 locked", rate_locked, 1);
    chk("R4 rate_sel", rate_sel, sel);
    chk("R4 baud_div", baud_div, n);
    send_cmd("R10 rate cmd", letter, n, code);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_parallel_owns();
    t_tolerance();
    t_commands();
    t_leave();
    t_rate(160, 1, 8'h44, 1);
    t_rate(320, 2, 8'h70, 6);
    t_rate(1280, 3, 8'h4B, 4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule